// File: doc/BRIEF.md
# Serial Flash Command Validator

This block sits at the front of a serial flash slave and turns the serial bit stream into checked commands. While the chip select is low it takes one bit from the data line on every rising edge of the serial clock, most significant bit first. The first complete byte is the opcode. The next three bytes form the address, and any further bytes are counted as data. The serial clock, chip select, data and busy inputs are assumed to be synchronous to, and slower than, the system clock `clk`. The block samples them there.

When chip select rises, the block judges the framed command. A write-type command (enable, disable, status write, page program, sector erase, block erase, chip erase, deep power-down) is accepted only in these cases:
- the number of serial clock edges was a whole number of bytes;
- the command has the length its opcode calls for;
- where it matters, the write-enable latch was set and no internal cycle was busy.

An accepted command produces a one-cycle execute pulse carrying a kind code, the raw opcode, the 24-bit address and a byte count. A rejected or unknown command vanishes without trace. The block owns the write-enable latch. The busy flag comes from the array controller outside.

Top module: `sflash_cmd_front`

## Requirements
- R1: While `rst_n` is low and in the first cycles after it, `exec_valid` is 0 and `wel` is 0.
- R2: Bits are assembled MSB first. The address reported for an accepted program or erase is byte 1, byte 2, byte 3 after the opcode, concatenated with byte 1 in bits 23:16.
- R3: A transaction whose number of serial clock rising edges is not a multiple of eight produces no execute pulse and leaves `wel` unchanged. This holds for a page program with a partial final byte as well.
- R4: Opcode 06h (kind 1) sets `wel`, and opcode 04h (kind 2) clears it. Each gives one execute pulse when framed as whole bytes.
- R5: Opcode 02h (page program, kind 4) needs the opcode, three address bytes and at least one data byte. With fewer it is dropped. `exec_len` is the number of data bytes.
- R6: Opcode 20h (sector erase, kind 5) and opcodes D8h or 52h (block erase, kind 6) are accepted only with exactly four bytes in total. Any other count is dropped.
- R7: Status write (01h, kind 3), program, sector erase, block erase and chip erase are dropped when `wel` is 0.
- R8: Status write, program and erase commands are dropped when `busy` is 1 at the moment chip select rises. `wel` then stays as it was.
- R9: An accepted status write, program or erase leaves `wel` at 0 in the cycle its execute pulse is high.
- R10: An opcode outside the supported set is dropped, and `wel` keeps its value.
- R11: `exec_valid` is high for exactly one `clk` cycle per accepted transaction. `exec_kind` is 1 for write enable, 2 for write disable, 3 for status write, 4 for program, 5 for sector erase, 6 for block erase, 7 for chip erase and 8 for deep power-down.
- R12: The page program data count in `exec_len` saturates at `PAGE_BYTES`.
- R13: Chip erase (C7h or 60h, kind 7) and deep power-down (B9h, kind 8) are accepted for any whole-byte length. Status write needs at least two bytes, and its `exec_len` is the count of bytes after the opcode.
- R14: All framing state clears while chip select is high, so a transaction aborted mid-byte does not disturb the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| sdi | input | 1 | Serial data in, sampled on sclk rising edges |
| busy | input | 1 | Internal write, program or erase cycle in progress |
| exec_valid | output | 1 | One-cycle pulse for an accepted command |
| exec_kind | output | 4 | Command kind code (see R11) |
| exec_op | output | 8 | Raw opcode of the accepted command |
| exec_addr | output | 24 | Address for program and erase, else 0 |
| exec_len | output | LEN_W | Data byte count (program) or byte count after opcode (status write) |
| wel | output | 1 | Write-enable latch |

## Verification
Three things are decided in the same clock cycle: the accept decision at chip select release, the sampling of `busy`, and the update of the write-enable latch. The bench drives `busy` so that it changes on the very edge at which chip select rises, in both directions. The judge is a bench model that uses the value of `busy` after the change. In the same cycle the bench checks that a pulse for a write-type command coincides with `wel` falling. It also checks that a rejected command leaves `wel` where it was.

// File: rtl/sfcv_pkg.sv
// Shared opcodes and command kinds for the serial flash command validator.
// Assumes one byte opcodes; kinds are the encoding seen on exec_kind.
package sfcv_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_SECT  = 8'h20;
    localparam logic [7:0] OP_BLK_A = 8'hD8;
    localparam logic [7:0] OP_BLK_B = 8'h52;
    localparam logic [7:0] OP_CHIP_A = 8'hC7;
    localparam logic [7:0] OP_CHIP_B = 8'h60;
    localparam logic [7:0] OP_SLEEP = 8'hB9;

    typedef enum logic [3:0] {
        K_NONE  = 4'd0,
        K_WREN  = 4'd1,
        K_WRDI  = 4'd2,
        K_WRSR  = 4'd3,
        K_PROG  = 4'd4,
        K_SECT  = 4'd5,
        K_BLK   = 4'd6,
        K_CHIP  = 4'd7,
        K_SLEEP = 4'd8
    } cmd_kind_e;

    // Map a raw opcode to its command kind.
    function automatic cmd_kind_e op_to_kind(input logic [7:0] op);
        case (op)
            OP_WREN:             return K_WREN;
            OP_WRDI:             return K_WRDI;
            OP_WRSR:             return K_WRSR;
            OP_PROG:             return K_PROG;
            OP_SECT:             return K_SECT;
            OP_BLK_A, OP_BLK_B:  return K_BLK;
            OP_CHIP_A, OP_CHIP_B: return K_CHIP;
            OP_SLEEP:            return K_SLEEP;
            default:             return K_NONE;
        endcase
    endfunction

    // True for kinds that modify the array or status and need the latch.
    function automatic logic kind_guarded(input cmd_kind_e k);
        return (k == K_WRSR) || (k == K_PROG) || (k == K_SECT) ||
               (k == K_BLK)  || (k == K_CHIP);
    endfunction

endpackage

// File: rtl/sfcv_sync_edge.sv
// Input stage: registers the serial pins in the clk domain and derives
// a bit strobe (sclk rising while selected) and the chip-select release.
// Assumes sclk, cs_n and sdi are synchronous to clk and sclk is at most
// a quarter of the clk rate.
module sfcv_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic bit_stb,
    output logic bit_val,
    output logic cs_end,
    output logic cs_idle
);

    logic sclk_s, sclk_p, cs_s, cs_p, di_s;

    // Sample pins and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_s <= 1'b0;
            sclk_p <= 1'b0;
            cs_s   <= 1'b1;
            cs_p   <= 1'b1;
            di_s   <= 1'b0;
        end else begin
            sclk_s <= sclk;
            sclk_p <= sclk_s;
            cs_s   <= cs_n;
            cs_p   <= cs_s;
            di_s   <= sdi;
        end
    end

    // Edge strobes from the sampled history.
    always_comb begin
        bit_stb = sclk_s & ~sclk_p & ~cs_s;
        bit_val = di_s;
        cs_end  = cs_s & ~cs_p;
        cs_idle = cs_s;
    end

endmodule

// File: rtl/sfcv_frame_collect.sv
// Frame collector: assembles bits MSB first into bytes, stores the opcode
// and the three address bytes, and counts whole bytes (saturating) plus
// the bits of an unfinished byte. All state clears while chip select is high.
module sfcv_frame_collect #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_stb,
    input  logic             bit_val,
    output logic [7:0]       opcode,
    output logic [23:0]      addr,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [2:0]       part_bits
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [6:0] shreg;
    logic [7:0] full_byte;

    // The byte completed by the current bit.
    always_comb full_byte = {shreg, bit_val};

    // Shift bits in, latch opcode and address bytes, count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            shreg     <= '0;
            opcode    <= '0;
            addr      <= '0;
            byte_cnt  <= '0;
            part_bits <= '0;
        end else if (bit_stb) begin
            shreg     <= full_byte[6:0];
            part_bits <= part_bits + 3'd1;
            if (part_bits == 3'd7) begin
                if (byte_cnt == '0) begin
                    opcode <= full_byte;
                end else if (byte_cnt <= CNT_W'(3)) begin
                    addr <= {addr[15:0], full_byte};
                end
                if (byte_cnt != CNT_MAX) begin
                    byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sfcv_rule_check.sv
// Rule check: purely combinational judgement of a framed command against
// byte alignment, per-opcode length rules, the write-enable latch and busy.
// Also forms the address and length fields reported with the pulse.
module sfcv_rule_check
    import sfcv_pkg::*;
#(
    parameter int CNT_W      = 9,
    parameter int LEN_W      = 9,
    parameter int PAGE_BYTES = 256
) (
    input  logic [7:0]       opcode,
    input  logic [23:0]      addr_in,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [2:0]       part_bits,
    input  logic             wel,
    input  logic             busy,
    output logic             accept,
    output cmd_kind_e        kind,
    output logic [23:0]      addr_out,
    output logic [LEN_W-1:0] len_out
);

    localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

    logic             len_ok;
    logic             guard_ok;
    logic [CNT_W-1:0] data_cnt;
    logic [CNT_W-1:0] tail_cnt;

    // Per-opcode length rule.
    always_comb begin
        kind = op_to_kind(opcode);
        case (kind)
            K_WRSR:       len_ok = byte_cnt >= CNT_W'(2);
            K_PROG:       len_ok = byte_cnt >= CNT_W'(5);
            K_SECT, K_BLK: len_ok = byte_cnt == CNT_W'(4);
            K_NONE:       len_ok = 1'b0;
            default:      len_ok = 1'b1;
        endcase
    end

    // Write-enable and busy gating for array and status writers.
    always_comb guard_ok = !kind_guarded(kind) || (wel && !busy);

    // Final verdict: opcode present, whole bytes, length and guard met.
    always_comb accept = (byte_cnt != '0) && (part_bits == 3'd0) && len_ok && guard_ok;

    // Reported fields: data count for program, trailing count for status write.
    always_comb begin
        data_cnt = byte_cnt - CNT_W'(4);
        tail_cnt = byte_cnt - CNT_W'(1);
        len_out  = '0;
        addr_out = '0;
        if (kind == K_PROG) begin
            len_out  = (data_cnt > PAGE_CNT) ? LEN_W'(PAGE_BYTES) : LEN_W'(data_cnt);
        end else if (kind == K_WRSR) begin
            len_out  = (tail_cnt > PAGE_CNT) ? LEN_W'(PAGE_BYTES) : LEN_W'(tail_cnt);
        end
        if (kind == K_PROG || kind == K_SECT || kind == K_BLK) begin
            addr_out = addr_in;
        end
    end

endmodule

// File: rtl/sfcv_wel_latch.sv
// Write-enable latch: set by an accepted enable, cleared by an accepted
// disable or by any accepted guarded command. Holds otherwise.
module sfcv_wel_latch
    import sfcv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire,
    input  cmd_kind_e kind,
    output logic      wel
);

    // Update the latch only on an accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (fire) begin
            if (kind == K_WREN) begin
                wel <= 1'b1;
            end else if (kind == K_WRDI || kind_guarded(kind)) begin
                wel <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sflash_cmd_front.sv
// Top of the serial flash command validator. Samples the serial pins,
// frames bytes, judges the command when chip select rises and issues a
// one-cycle execute pulse with kind, opcode, address and length.
// Assumes serial pins and busy are synchronous to clk.
module sflash_cmd_front
    import sfcv_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             sdi,
    input  logic             busy,
    output logic             exec_valid,
    output logic [3:0]       exec_kind,
    output logic [7:0]       exec_op,
    output logic [23:0]      exec_addr,
    output logic [LEN_W-1:0] exec_len,
    output logic             wel
);

    localparam int CNT_W = $clog2(PAGE_BYTES + 6);

    logic             bit_stb, bit_val, cs_end, cs_idle;
    logic [7:0]       opcode;
    logic [23:0]      addr_q;
    logic [CNT_W-1:0] byte_cnt;
    logic [2:0]       part_bits;
    logic             accept, fire;
    cmd_kind_e        kind;
    logic [23:0]      addr_rep;
    logic [LEN_W-1:0] len_rep;

    sfcv_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .sdi     (sdi),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .cs_end  (cs_end),
        .cs_idle (cs_idle)
    );

    sfcv_frame_collect #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (cs_idle),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .opcode    (opcode),
        .addr      (addr_q),
        .byte_cnt  (byte_cnt),
        .part_bits (part_bits)
    );

    sfcv_rule_check #(
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_rules (
        .opcode    (opcode),
        .addr_in   (addr_q),
        .byte_cnt  (byte_cnt),
        .part_bits (part_bits),
        .wel       (wel),
        .busy      (busy),
        .accept    (accept),
        .kind      (kind),
        .addr_out  (addr_rep),
        .len_out   (len_rep)
    );

    // A command fires only at the chip-select release.
    always_comb fire = cs_end & accept;

    sfcv_wel_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .kind  (kind),
        .wel   (wel)
    );

    // Register the execute pulse and its fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_valid <= 1'b0;
            exec_kind  <= '0;
            exec_op    <= '0;
            exec_addr  <= '0;
            exec_len   <= '0;
        end else begin
            exec_valid <= fire;
            if (fire) begin
                exec_kind <= kind;
                exec_op   <= opcode;
                exec_addr <= addr_rep;
                exec_len  <= len_rep;
            end
        end
    end

endmodule

// File: rtl/sflash_cmd_front_chk.sv
// Checker for sflash_cmd_front: temporal properties on its ports,
// attached by bind.
module sflash_cmd_front_chk #(
    parameter int LEN_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             exec_valid,
    input logic [3:0]       exec_kind,
    input logic [LEN_W-1:0] exec_len,
    input logic             wel
);

    logic guarded;
    always_comb guarded = (exec_kind >= 4'd3) && (exec_kind <= 4'd7);

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> !exec_valid); // R11
    AST_WEL_ONLY_ON_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wel) |-> exec_valid); // R3
    AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 4'd1) |-> wel); // R4
    AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 4'd2) |-> !wel); // R4
    AST_GUARD_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && guarded) |-> !wel); // R9
    AST_GUARD_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && guarded) |-> $past(wel)); // R7
    AST_GUARD_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && guarded) |-> !$past(busy)); // R8
    AST_PROG_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 4'd4) |-> (exec_len != '0)); // R5
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> (exec_kind != 4'd0 && exec_kind <= 4'd8)); // R11

endmodule

bind sflash_cmd_front sflash_cmd_front_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .exec_valid (exec_valid),
    .exec_kind  (exec_kind),
    .exec_len   (exec_len),
    .wel        (wel)
);

// File: tb/sflash_cmd_front_bench.sv
module sflash_cmd_front_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PAGE       = 256;
    localparam int LW         = $clog2(PAGE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic busy = 1'b0;
    logic          exec_valid;
    logic [3:0]    exec_kind;
    logic [7:0]    exec_op;
    logic [23:0]   exec_addr;
    logic [LW-1:0] exec_len;
    logic          wel;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 0;
    logic [3:0]    cap_kind;
    logic [7:0]    cap_op;
    logic [23:0]   cap_addr;
    logic [LW-1:0] cap_len;
    logic          cap_wel;
    logic          m_wel = 1'b0;
    logic [7:0]    txq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_cmd_front #(.PAGE_BYTES(PAGE)) u_sflash_cmd_front (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .busy(busy), .exec_valid(exec_valid), .exec_kind(exec_kind),
        .exec_op(exec_op), .exec_addr(exec_addr), .exec_len(exec_len), .wel(wel)
    );

    // Capture pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && exec_valid) begin
            pulses   <= pulses + 1;
            cap_kind <= exec_kind;
            cap_op   <= exec_op;
            cap_addr <= exec_addr;
            cap_len  <= exec_len;
            cap_wel  <= wel;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    function automatic int kind_of(input logic [7:0] op);
        case (op)
            8'h06: return 1;
            8'h04: return 2;
            8'h01: return 3;
            8'h02: return 4;
            8'h20: return 5;
            8'hD8, 8'h52: return 6;
            8'hC7, 8'h60: return 7;
            8'hB9: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic bit len_rule(input int k, input int nb);
        case (k)
            0: return 0;
            3: return nb >= 2;
            4: return nb >= 5;
            5, 6: return nb == 4;
            default: return 1;
        endcase
    endfunction

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sdi = b;
        sclk = 1'b0;
        wait_clk(2);
        sclk = 1'b1;
        wait_clk(2);
    endtask

    // One transaction: op, nb whole bytes, tail extra bits, busy level,
    // mode 1 flips busy on the same edge as chip select release.
    task automatic txn(input string tag, input logic [7:0] op, input int nb,
                       input int tail, input logic [23:0] adr, input logic bz, input int mode);
        logic bz_end;
        int   k;
        bit   acc;
        int   e_len;
        logic [23:0] e_addr;
        txq.delete();
        txq.push_back(op);
        txq.push_back(adr[23:16]);
        txq.push_back(adr[15:8]);
        txq.push_back(adr[7:0]);
        while (txq.size() < nb + 1) txq.push_back(8'($urandom));
        busy = bz;
        wait_clk(1);
        pulses = 0;
        cs_n = 1'b0;
        wait_clk(2);
        for (int i = 0; i < nb; i++)
            for (int j = 7; j >= 0; j--) send_bit(txq[i][j]);
        for (int j = 7; j > 7 - tail; j--) send_bit(txq[nb][j]);
        sclk = 1'b0;
        wait_clk(2);
        cs_n = 1'b1;
        if (mode == 1) busy = ~busy;
        bz_end = busy;
        wait_clk(8);
        busy = 1'b0;
        // Model from the requirements.
        k = (nb >= 1) ? kind_of(op) : 0;
        acc = (nb >= 1) && (tail == 0) && len_rule(k, nb) &&
              (!(k >= 3 && k <= 7) || (m_wel && !bz_end));
        e_len = (k == 4) ? ((nb - 4 > PAGE) ? PAGE : nb - 4) : (k == 3) ? nb - 1 : 0;
        e_addr = (k >= 4 && k <= 6) ? {txq[1], txq[2], txq[3]} : 24'd0;
        if (acc) begin
            if (k == 1) m_wel = 1'b1;
            else if (k == 2 || (k >= 3 && k <= 7)) m_wel = 1'b0;
        end
        chk({tag, " R11 pulse count"}, pulses, acc ? 1 : 0);
        if (acc && pulses == 1) begin
            chk({tag, " R11 kind"}, int'(cap_kind), k);
            chk({tag, " R2 addr"}, int'(cap_addr), int'(e_addr));
            chk({tag, " R5 len"}, int'(cap_len), e_len);
            chk({tag, " R11 opcode"}, int'(cap_op), int'(op));
            if (k >= 3 && k <= 7) chk({tag, " R9 wel at pulse"}, int'(cap_wel), 0);
        end
        chk({tag, " R3 wel"}, int'(wel), int'(m_wel));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        wait_clk(2);
        chk("R1 exec_valid in reset", int'(exec_valid), 0);
        chk("R1 wel in reset", int'(wel), 0);
        wait_clk(2);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 exec_valid after reset", int'(exec_valid), 0);
        chk("R1 wel after reset", int'(wel), 0);

        txn("R10 unknown", 8'hAB, 1, 0, 24'h0, 1'b0, 0);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R10 unknown keeps wel", 8'h9F, 4, 0, 24'h0, 1'b0, 0);
        txn("R2 R6 sector", 8'h20, 4, 0, 24'h123456, 1'b0, 0);
        chk("R2 sector address", int'(cap_addr), 24'h123456);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R6 sector long", 8'h20, 5, 0, 24'hABCDEF, 1'b0, 0);
        txn("R6 block short", 8'hD8, 3, 0, 24'h010203, 1'b0, 0);
        txn("R6 block 52h", 8'h52, 4, 0, 24'hFEDCBA, 1'b0, 0);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R5 prog no data", 8'h02, 4, 0, 24'h000100, 1'b0, 0);
        txn("R3 prog partial", 8'h02, 5, 3, 24'h000100, 1'b0, 0);
        txn("R5 prog one byte", 8'h02, 5, 0, 24'h000100, 1'b0, 0);
        txn("R7 prog no wel", 8'h02, 6, 0, 24'h000200, 1'b0, 0);
        txn("R7 chip no wel", 8'hC7, 1, 0, 24'h0, 1'b0, 0);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R8 sector busy", 8'h20, 4, 0, 24'h000010, 1'b1, 0);
        txn("R8 busy rises at release", 8'h20, 4, 0, 24'h000020, 1'b0, 1);
        txn("R8 busy falls at release", 8'h20, 4, 0, 24'h000030, 1'b1, 1);
        txn("R14 aborted bits", 8'h06, 0, 3, 24'h0, 1'b0, 0);
        txn("R14 wren after abort", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R4 wrdi", 8'h04, 1, 0, 24'h0, 1'b0, 0);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R13 chip 60h", 8'h60, 2, 0, 24'h0, 1'b0, 0);
        txn("R13 sleep", 8'hB9, 1, 0, 24'h0, 1'b0, 0);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R13 status write", 8'h01, 2, 0, 24'h0, 1'b0, 0);
        txn("R4 wren", 8'h06, 1, 0, 24'h0, 1'b0, 0);
        txn("R12 prog saturate", 8'h02, 4 + PAGE + 3, 0, 24'h00F000, 1'b0, 0);
        chk("R12 saturated length", int'(cap_len), PAGE);

        for (int t = 0; t < 70; t++) begin
            logic [7:0] ops[13] = '{8'h06, 8'h04, 8'h01, 8'h02, 8'h20, 8'hD8, 8'h52,
                                    8'hC7, 8'h60, 8'hB9, 8'h06, 8'h03, 8'h06};
            int nb = 1 + int'($urandom % 7);
            int tl = ($urandom % 4 == 0) ? 1 + int'($urandom % 7) : 0;
            logic bz = ($urandom % 5 == 0);
            int md = ($urandom % 8 == 0) ? 1 : 0;
            txn("random R6 R7 R8", ops[$urandom % 13], nb, tl, 24'($urandom), bz, md);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule